// File: doc/BRIEF.md
# Reservation Switch Allocator for a Mesh Control-Plane Router

This block decides, cycle by cycle, which reservation packets leave a five-port mesh router (local, north, east, south, west). Each input offers at most one reservation packet carrying the destination's X and Y coordinates. The block steers the packet with dimension-ordered routing, X first and then Y. It then arbitrates among the inputs that want the same output.

A reservation packet wins its output only when two queues can accept the booking. The first is the future-output queue of its input. The second is the future-input queue of the chosen output. Both queues live in the companion data-plane router. When a packet wins, the block raises both enqueue strobes in the same cycle. The input's queue receives the output number and the output's queue receives the input number. The packet's destination is also driven onto that output.

A packet that cannot book its reservation gets no grant and stays at its input. It competes again in every later cycle until it succeeds. Later packets are queued behind earlier ones and never dropped. Among inputs that contend in the same cycle, a rotating priority per output shares the bandwidth fairly.

Top module: `rsv_switch_alloc`

## Requirements
- R1: Port codes are local=0, north=1, east=2, south=3, west=4. A packet whose destination X is greater than the router's X goes east, and one whose destination X is smaller goes west. When X matches, a greater Y goes north, a smaller Y goes south, and an equal Y goes local.
- R2: An input is granted only when its own future-output queue is not full (`qout_full[i]`=0) and the chosen output's future-input queue is not full (`qin_full[o]`=0), both sampled in the granting cycle.
- R3: In a granting cycle, `qout_push[i]` is high with `qout_port[i]`=o, and `qin_push[o]` is high with `qin_port[o]`=i. The two strobes always appear together.
- R4: Each output grants at most one input per cycle, and each input is granted at most once per cycle.
- R5: A packet that is refused receives no push. It is granted in the first cycle after the blocking full flag drops, provided it still presents itself.
- R6: Each output uses rotating priority. After input i wins an output, the search for that output's next winner starts at input i+1, wrapping from 4 to 0.
- R7: A winning packet is forwarded on its output: `out_vld[o]` is high and `out_dx[o]`/`out_dy[o]` equal the winner's destination. Outputs that grant nothing hold `out_vld` low.
- R8: Reset sets every output's priority so that the search starts at input 0. Inputs whose `in_vld` is low raise no strobe, even when their queues have room.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 5 | Reservation packet present, per input |
| in_dx | input | 5 x CW | Destination X, per input |
| in_dy | input | 5 x CW | Destination Y, per input |
| qout_full | input | 5 | Future-output queue of each input is full |
| qin_full | input | 5 | Future-input queue of each output is full |
| qout_push | output | 5 | Enqueue into input's future-output queue, which is also the grant to that input |
| qout_port | output | 5 x 3 | Output code written into that input's queue |
| qin_push | output | 5 | Enqueue into output's future-input queue |
| qin_port | output | 5 x 3 | Input number written into that output's queue |
| out_vld | output | 5 | Reservation packet leaves on this output |
| out_dx | output | 5 x CW | Forwarded destination X |
| out_dy | output | 5 x CW | Forwarded destination Y |

## Verification
The bench builds the block with 3-bit coordinates and places the router at (2,2). With that position, destinations exist on both sides of the router in both dimensions. All five output directions, including local, can therefore be reached in a single cycle. The same parameters let three or more inputs pile onto one output, so the priority can be seen wrapping from input 4 back to input 0. They also allow each full flag to be raised separately while a competing packet proceeds.

// File: rtl/rsv_alloc_pkg.sv
package rsv_alloc_pkg;

    localparam int NUM_PORTS = 5;
    localparam int PORT_W    = 3;

    typedef enum logic [PORT_W-1:0] {
        PORT_LOCAL = 3'd0,
        PORT_NORTH = 3'd1,
        PORT_EAST  = 3'd2,
        PORT_SOUTH = 3'd3,
        PORT_WEST  = 3'd4
    } port_e;

    function automatic logic [PORT_W-1:0] wrap_next(input logic [PORT_W-1:0] idx);
        return (idx == PORT_W'(NUM_PORTS - 1)) ? '0 : idx + 1'b1;
    endfunction

endpackage

// File: rtl/rsv_xy_route.sv
module rsv_xy_route
    import rsv_alloc_pkg::*;
#(
    parameter int CW   = 3,
    parameter int MY_X = 2,
    parameter int MY_Y = 2
) (
    input  logic [CW-1:0] dx,
    input  logic [CW-1:0] dy,
    output port_e         dir
);
    localparam logic [CW-1:0] HX = CW'(MY_X);
    localparam logic [CW-1:0] HY = CW'(MY_Y);

    always_comb begin
        if (dx > HX)      dir = PORT_EAST;
        else if (dx < HX) dir = PORT_WEST;
        else if (dy > HY) dir = PORT_NORTH;
        else if (dy < HY) dir = PORT_SOUTH;
        else              dir = PORT_LOCAL;
    end
endmodule

// File: rtl/rsv_rr_arb.sv
module rsv_rr_arb
    import rsv_alloc_pkg::*;
#(
    parameter int N = NUM_PORTS
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [N-1:0]       req,
    output logic [N-1:0]       gnt,
    output logic               any,
    output logic [PORT_W-1:0]  win
);
    logic [PORT_W-1:0] ptr;
    int                cand;

    always_comb begin
        any  = 1'b0;
        win  = '0;
        cand = 0;
        for (int k = 0; k < N; k++) begin
            cand = (int'(ptr) + k) % N;
            if (!any && req[cand]) begin
                any = 1'b1;
                win = PORT_W'(cand);
            end
        end
        gnt = '0;
        if (any) gnt[win] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)      ptr <= '0;
        else if (any) ptr <= wrap_next(win);
    end
endmodule

// File: rtl/rsv_switch_alloc.sv
module rsv_switch_alloc
    import rsv_alloc_pkg::*;
#(
    parameter int CW   = 3,
    parameter int MY_X = 2,
    parameter int MY_Y = 2
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic [NUM_PORTS-1:0]              in_vld,
    input  logic [NUM_PORTS-1:0][CW-1:0]      in_dx,
    input  logic [NUM_PORTS-1:0][CW-1:0]      in_dy,
    input  logic [NUM_PORTS-1:0]              qout_full,
    input  logic [NUM_PORTS-1:0]              qin_full,
    output logic [NUM_PORTS-1:0]              qout_push,
    output logic [NUM_PORTS-1:0][PORT_W-1:0]  qout_port,
    output logic [NUM_PORTS-1:0]              qin_push,
    output logic [NUM_PORTS-1:0][PORT_W-1:0]  qin_port,
    output logic [NUM_PORTS-1:0]              out_vld,
    output logic [NUM_PORTS-1:0][CW-1:0]      out_dx,
    output logic [NUM_PORTS-1:0][CW-1:0]      out_dy
);
    port_e                             dir  [NUM_PORTS];
    logic [NUM_PORTS-1:0][NUM_PORTS-1:0] req_m;
    logic [NUM_PORTS-1:0][NUM_PORTS-1:0] gnt_m;
    logic [NUM_PORTS-1:0]              any_o;
    logic [NUM_PORTS-1:0][PORT_W-1:0]  win_o;

    for (genvar i = 0; i < NUM_PORTS; i++) begin : g_in
        rsv_xy_route #(.CW(CW), .MY_X(MY_X), .MY_Y(MY_Y)) u_route (
            .dx  (in_dx[i]),
            .dy  (in_dy[i]),
            .dir (dir[i])
        );
    end

    for (genvar o = 0; o < NUM_PORTS; o++) begin : g_out
        for (genvar i = 0; i < NUM_PORTS; i++) begin : g_req
            assign req_m[o][i] = in_vld[i] && (dir[i] == port_e'(o))
                               && !qout_full[i] && !qin_full[o];
        end

        rsv_rr_arb #(.N(NUM_PORTS)) u_arb (
            .clk (clk),
            .rst (rst),
            .req (req_m[o]),
            .gnt (gnt_m[o]),
            .any (any_o[o]),
            .win (win_o[o])
        );

        assign qin_push[o] = any_o[o];
        assign qin_port[o] = any_o[o] ? win_o[o] : '0;
        assign out_vld[o]  = any_o[o];
        assign out_dx[o]   = any_o[o] ? in_dx[win_o[o]] : '0;
        assign out_dy[o]   = any_o[o] ? in_dy[win_o[o]] : '0;
    end

    always_comb begin
        for (int i = 0; i < NUM_PORTS; i++) begin
            qout_push[i] = 1'b0;
            for (int o = 0; o < NUM_PORTS; o++) begin
                qout_push[i] = qout_push[i] | gnt_m[o][i];
            end
            qout_port[i] = qout_push[i] ? PORT_W'(dir[i]) : '0;
        end
    end
endmodule

// File: rtl/rsv_switch_alloc_chk.sv
module rsv_switch_alloc_chk
    import rsv_alloc_pkg::*;
(
    input logic                              clk,
    input logic                              rst,
    input logic [NUM_PORTS-1:0]              in_vld,
    input logic [NUM_PORTS-1:0]              qout_full,
    input logic [NUM_PORTS-1:0]              qin_full,
    input logic [NUM_PORTS-1:0]              qout_push,
    input logic [NUM_PORTS-1:0][PORT_W-1:0]  qout_port,
    input logic [NUM_PORTS-1:0]              qin_push,
    input logic [NUM_PORTS-1:0][PORT_W-1:0]  qin_port,
    input logic [NUM_PORTS-1:0]              out_vld
);
    assert_push_balance_R3: assert property (@(posedge clk) disable iff (rst)
        $countones(qout_push) == $countones(qin_push));

    for (genvar i = 0; i < NUM_PORTS; i++) begin : g_chk
        assert_no_overflow_out_R2: assert property (@(posedge clk) disable iff (rst)
            qout_push[i] |-> !qout_full[i]);
        assert_no_overflow_in_R2: assert property (@(posedge clk) disable iff (rst)
            qin_push[i] |-> !qin_full[i]);
        assert_pair_match_R3: assert property (@(posedge clk) disable iff (rst)
            qout_push[i] |-> (qin_push[qout_port[i]] && qin_port[qout_port[i]] == PORT_W'(i)));
        assert_idle_input_R8: assert property (@(posedge clk) disable iff (rst)
            !in_vld[i] |-> !qout_push[i]);
        assert_forward_R7: assert property (@(posedge clk) disable iff (rst)
            out_vld[i] == qin_push[i]);
    end
endmodule

bind rsv_switch_alloc rsv_switch_alloc_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_vld    (in_vld),
    .qout_full (qout_full),
    .qin_full  (qin_full),
    .qout_push (qout_push),
    .qout_port (qout_port),
    .qin_push  (qin_push),
    .qin_port  (qin_port),
    .out_vld   (out_vld)
);

// File: tb/rsv_switch_alloc_tb.sv
module rsv_switch_alloc_tb;
    localparam int NP = 5;
    localparam int CW = 3;
    localparam int NV = 9;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic [NP-1:0]          in_vld = '0;
    logic [NP-1:0][CW-1:0]  in_dx = '0;
    logic [NP-1:0][CW-1:0]  in_dy = '0;
    logic [NP-1:0]          qout_full = '0;
    logic [NP-1:0]          qin_full = '0;
    logic [NP-1:0]          qout_push;
    logic [NP-1:0][2:0]     qout_port;
    logic [NP-1:0]          qin_push;
    logic [NP-1:0][2:0]     qin_port;
    logic [NP-1:0]          out_vld;
    logic [NP-1:0][CW-1:0]  out_dx;
    logic [NP-1:0][CW-1:0]  out_dy;

    int nchk = 0;
    int nfail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    rsv_switch_alloc #(.CW(CW), .MY_X(2), .MY_Y(2)) u_dut (
        .clk(clk), .rst(rst), .in_vld(in_vld), .in_dx(in_dx), .in_dy(in_dy),
        .qout_full(qout_full), .qin_full(qin_full),
        .qout_push(qout_push), .qout_port(qout_port),
        .qin_push(qin_push), .qin_port(qin_port),
        .out_vld(out_vld), .out_dx(out_dx), .out_dy(out_dy)
    );

    // vector table, bit/field order {in4, in3, in2, in1, in0}
    localparam logic [4:0]  T_VLD [NV] = '{5'b00000, 5'b11111, 5'b00111, 5'b00111, 5'b00111,
                                           5'b00111, 5'b00110, 5'b11000, 5'b11000};
    localparam logic [4:0]  T_QOF [NV] = '{5'b0, 5'b0, 5'b0, 5'b0, 5'b0, 5'b00010, 5'b0, 5'b0, 5'b0};
    localparam logic [4:0]  T_QIF [NV] = '{5'b0, 5'b0, 5'b0, 5'b0, 5'b0, 5'b00010, 5'b0, 5'b0, 5'b0};
    localparam logic [14:0] T_DX  [NV] = '{
        {3'd2,3'd2,3'd2,3'd2,3'd2}, {3'd2,3'd2,3'd2,3'd1,3'd3},
        {3'd2,3'd2,3'd5,3'd5,3'd5}, {3'd2,3'd2,3'd5,3'd5,3'd5}, {3'd2,3'd2,3'd5,3'd5,3'd5},
        {3'd2,3'd2,3'd2,3'd0,3'd7}, {3'd2,3'd2,3'd2,3'd0,3'd7},
        {3'd2,3'd2,3'd2,3'd2,3'd2}, {3'd2,3'd2,3'd2,3'd2,3'd2}};
    localparam logic [14:0] T_DY  [NV] = '{
        {3'd2,3'd2,3'd2,3'd2,3'd2}, {3'd2,3'd0,3'd3,3'd2,3'd2},
        {3'd2,3'd2,3'd7,3'd7,3'd7}, {3'd2,3'd2,3'd7,3'd7,3'd7}, {3'd2,3'd2,3'd7,3'd7,3'd7},
        {3'd2,3'd2,3'd7,3'd5,3'd2}, {3'd2,3'd2,3'd7,3'd5,3'd2},
        {3'd1,3'd1,3'd2,3'd2,3'd2}, {3'd1,3'd1,3'd2,3'd2,3'd2}};
    localparam logic [4:0]  T_EXP [NV] = '{5'b00000, 5'b11111, 5'b00010, 5'b00100, 5'b00001,
                                           5'b00001, 5'b00110, 5'b10000, 5'b01000};

    // R1 routing rule for a router at (2,2)
    function automatic logic [2:0] exp_dir(input logic [CW-1:0] x, input logic [CW-1:0] y);
        if (x > 3'd2)      return 3'd2;
        else if (x < 3'd2) return 3'd4;
        else if (y > 3'd2) return 3'd1;
        else if (y < 3'd2) return 3'd3;
        else               return 3'd0;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // checks all outputs against an expected grant vector
    task automatic check_all(input string req, input logic [NP-1:0] g);
        logic [NP-1:0]         e_qin;
        logic [NP-1:0][2:0]    e_qinp;
        logic [NP-1:0][2:0]    e_qoutp;
        logic [NP-1:0][CW-1:0] e_dx;
        logic [NP-1:0][CW-1:0] e_dy;
        e_qin = '0; e_qinp = '0; e_qoutp = '0; e_dx = '0; e_dy = '0;
        for (int i = 0; i < NP; i++) begin
            if (g[i]) begin
                logic [2:0] o;
                o = exp_dir(in_dx[i], in_dy[i]);
                e_qoutp[i] = o;
                e_qin[o]   = 1'b1;
                e_qinp[o]  = 3'(i);
                e_dx[o]    = in_dx[i];
                e_dy[o]    = in_dy[i];
            end
        end
        chk({req, " grant/R4"}, 32'(qout_push), 32'(g));
        chk({req, " qout_port/R1 R3"}, 32'(qout_port), 32'(e_qoutp));
        chk({req, " qin_push/R3"}, 32'(qin_push), 32'(e_qin));
        chk({req, " qin_port/R3"}, 32'(qin_port), 32'(e_qinp));
        chk({req, " out_vld/R7"}, 32'(out_vld), 32'(e_qin));
        chk({req, " out_dest/R7"}, 32'({out_dx, out_dy}), 32'({e_dx, e_dy}));
    endtask

    task automatic drive(input logic [4:0] v, input logic [4:0] qof, input logic [4:0] qif,
                         input logic [14:0] dx, input logic [14:0] dy);
        @(posedge clk);
        #1;
        in_vld = v; qout_full = qof; qin_full = qif; in_dx = dx; in_dy = dy;
        @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            nchk++; nfail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_all("R8 reset", 5'b0);
        #1 rst = 1'b0;

        // table: R1 R2 R4 R6 R7 R8
        for (int n = 0; n < NV; n++) begin
            drive(T_VLD[n], T_QOF[n], T_QIF[n], T_DX[n], T_DY[n]);
            check_all($sformatf("R6 table vector %0d", n), T_EXP[n]);
        end

        // R8: inputs 1 and 3 east; input 1 wins, then reset restores start at 0
        drive(5'b01010, 5'b0, 5'b0, {3'd2,3'd6,3'd2,3'd6,3'd2}, {3'd2,3'd2,3'd2,3'd2,3'd2});
        check_all("R8 pre-reset", 5'b00010);
        @(posedge clk); #1 rst = 1'b1;
        @(posedge clk); #1 rst = 1'b0;
        @(negedge clk);
        check_all("R8 after reset restart", 5'b00010);

        // R5: blocked by output queue full for three cycles, then granted
        for (int k = 0; k < 3; k++) begin
            drive(5'b00001, 5'b0, 5'b00100, {3'd2,3'd2,3'd2,3'd2,3'd7}, {3'd2,3'd2,3'd2,3'd2,3'd4});
            check_all("R5 blocked wait", 5'b0);
        end
        drive(5'b00001, 5'b0, 5'b0, {3'd2,3'd2,3'd2,3'd2,3'd7}, {3'd2,3'd2,3'd2,3'd2,3'd4});
        check_all("R5 retry succeeds", 5'b00001);

        // R2: input queue full blocks only that input on the same output
        drive(5'b00011, 5'b00001, 5'b0, {3'd2,3'd2,3'd2,3'd2,3'd2}, {3'd2,3'd2,3'd2,3'd0,3'd0});
        check_all("R2 own queue full", 5'b00010);

        // R8: idle inputs with free queues produce nothing
        drive(5'b00000, 5'b0, 5'b0, {3'd7,3'd0,3'd2,3'd2,3'd7}, {3'd2,3'd2,3'd7,3'd0,3'd2});
        check_all("R8 invalid ignored", 5'b0);

        // R6 wrap: inputs 0 and 4 local; pointer for local output cycles
        drive(5'b10001, 5'b0, 5'b0, {3'd2,3'd2,3'd2,3'd2,3'd2}, {3'd2,3'd2,3'd2,3'd2,3'd2});
        check_all("R6 local first", 5'b00001);
        drive(5'b10001, 5'b0, 5'b0, {3'd2,3'd2,3'd2,3'd2,3'd2}, {3'd2,3'd2,3'd2,3'd2,3'd2});
        check_all("R6 local second", 5'b10000);
        drive(5'b10001, 5'b0, 5'b0, {3'd2,3'd2,3'd2,3'd2,3'd2}, {3'd2,3'd2,3'd2,3'd2,3'd2});
        check_all("R6 local wrap", 5'b00001);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule